// File: doc/BRIEF.md
# Half-Duplex SPI Shift Engine with Byte-Boundary Pin Turnaround

This block shifts bytes over an SPI link whose single data pin can carry traffic in either direction. A byte written while the engine is idle goes straight into the shift register and starts a transfer. A byte written during a transfer waits in a one-entry holding register and follows the current byte with no gap. The serial clock comes from an external tick. Each tick is one half-period, so a byte takes sixteen ticks.

A software-controlled receive-enable input selects the pin direction. While the engine is idle, the direction output tracks that input directly. During a transfer the engine captures it at only two points: when a byte is loaded from idle, and on the final tick of each byte. The pin buffer therefore never reverses inside a byte. The hardware adds no turnaround delay. Software that needs a gap waits for the busy flag to fall before it flips the direction and writes the next byte.

Top module: `spi_turnaround_shifter`

## Requirements
- R1: After reset, busy, hold_full, rx_valid and rx_data are all 0, and sclk equals cpol.
- R2: While idle, sdo_oe equals the inverse of rx_en in the same cycle, and sclk equals cpol.
- R3: A wr_en pulse while idle sets busy on the next cycle. The byte is loaded for shifting and the direction is captured from rx_en at that moment.
- R4: While busy, sdo_oe changes only on the final tick of a byte. A change of rx_en at any other time has no effect on sdo_oe until that tick.
- R5: While busy, every bit_tick toggles sclk, and a byte ends on its sixteenth tick. Ticks while idle change neither sclk nor busy.
- R6: Data leaves MSB first on sdo. With cpha=0 the first bit is on sdo from the load, and later bits appear after the odd-numbered (trailing) ticks. With cpha=1 each bit appears after the even-numbered (leading) ticks, counting from tick 0.
- R7: sdi is sampled on even-numbered ticks when cpha=0 and on odd-numbered ticks when cpha=1. The first sampled bit lands in bit 7 of the received byte.
- R8: At the end of a byte shifted in the input direction, rx_data takes the received byte and rx_valid pulses for one cycle. At the end of a byte in the output direction, rx_data keeps its value and rx_valid stays 0.
- R9: A write while busy with the holding register empty sets hold_full. At the end of the current byte that data is loaded with no idle cycle: busy stays 1 and hold_full clears.
- R10: A write while busy and hold_full is 1 is ignored.
- R11: With no byte waiting, busy falls on the final tick of the byte. A write on the next cycle starts a new byte at once.
- R12: When sdo_oe is 0, sdo is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edges; 1: sample on trailing edges |
| rx_en | input | 1 | 1 selects input direction for the data pin |
| bit_tick | input | 1 | One serial clock half-period elapsed |
| wr_en | input | 1 | Write strobe for a transmit byte |
| wr_data | input | W | Transmit byte |
| sdi | input | 1 | Serial data from the pin buffer |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the pin buffer |
| sdo_oe | output | 1 | Pin buffer drive enable (1 = output) |
| busy | output | 1 | Transfer in progress |
| hold_full | output | 1 | Holding register occupied |
| rx_data | output | W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data updates |

## Verification
The assertions assume that cpol and cpha stay constant while busy is high. They also assume that bit_tick pulses are spaced so that a byte spans more than one clock. The bench changes polarity and phase only between transfers, when busy is 0. It issues each tick as a single-cycle pulse with at least one idle cycle between pulses. It flips rx_en inside bytes on purpose, to exercise the rule that the direction is captured only at the byte boundary.

// File: rtl/spi_turnaround_shifter.sv
`timescale 1ns/1ps
module spi_turnaround_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         rx_en,
  input  logic         bit_tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         sdi,
  output logic         sclk,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         busy,
  output logic         hold_full,
  output logic [W-1:0] rx_data,
  output logic         rx_valid
);
  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] LAST = CW'(2 * W - 1);

  logic          active, dir_q, full_q, sclk_q, rxv_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  hold_q, sh_q, rsh_q, rx_q;

  wire step       = active & bit_tick;
  wire lead       = ~cnt[0];
  wire byte_end   = step & (cnt == LAST);
  wire do_shift   = step & (cpha ? (lead & (cnt != '0)) : (~lead & (cnt != LAST)));
  wire do_samp    = step & (cpha ? ~lead : lead);
  wire load_first = wr_en & ~active;
  wire next_ready = full_q | wr_en;
  wire [W-1:0] next_byte = full_q ? hold_q : wr_data;
  wire [W-1:0] rx_word   = cpha ? {rsh_q[W-2:0], sdi} : rsh_q;
  wire hold_take  = wr_en & active & ~full_q & ~byte_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      dir_q  <= 1'b1;
      cnt    <= '0;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      rsh_q  <= '0;
      rx_q   <= '0;
      rxv_q  <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (load_first) begin
        active <= 1'b1;
        sh_q   <= wr_data;
        dir_q  <= ~rx_en;
        cnt    <= '0;
        sclk_q <= cpol;
      end else if (step) begin
        sclk_q <= ~sclk_q;
        if (byte_end) begin
          if (!dir_q) begin
            rx_q  <= rx_word;
            rxv_q <= 1'b1;
          end
          cnt <= '0;
          if (next_ready) begin
            sh_q  <= next_byte;
            dir_q <= ~rx_en;
          end else begin
            active <= 1'b0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (do_shift) sh_q  <= {sh_q[W-2:0], 1'b0};
          if (do_samp)  rsh_q <= {rsh_q[W-2:0], sdi};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (byte_end) begin
      full_q <= 1'b0;
    end else if (hold_take) begin
      full_q <= 1'b1;
      hold_q <= wr_data;
    end
  end

  assign sclk      = active ? sclk_q : cpol;
  assign sdo_oe    = active ? dir_q : ~rx_en;
  assign sdo       = sdo_oe & sh_q[W-1];
  assign busy      = active;
  assign hold_full = full_q;
  assign rx_data   = rx_q;
  assign rx_valid  = rxv_q;

  AST_START_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en) |=> busy); // R3
  AST_DIR_HELD_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_end) |=> $stable(sdo_oe)); // R4
  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_tick) |=> (!$stable(cpol) || sclk != $past(sclk))); // R5
  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> (!$stable(cpol) || sclk == $past(sclk))); // R5
  AST_RX_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data)); // R8
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8
  AST_GAPLESS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(hold_full) && !hold_full) |-> busy); // R9
endmodule

// File: tb/spi_turnaround_shifter_test.sv
`timescale 1ns/1ps
module spi_turnaround_shifter_test;
  logic clk = 0, rst_n = 0, cpol = 0, cpha = 0, rx_en = 0, bit_tick = 0, wr_en = 0, sdi = 0;
  logic [7:0] wr_data = '0;
  logic sclk, sdo, sdo_oe, busy, hold_full, rx_valid;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_turnaround_shifter #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .rx_en(rx_en),
    .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .hold_full(hold_full),
    .rx_data(rx_data), .rx_valid(rx_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic d);
    bit_tick = 1; sdi = d;
    @(negedge clk);
    bit_tick = 0;
    @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(hold_full == 0, "R1 hold_full", hold_full, 0);
    chk(rx_valid == 0 && rx_data == 0, "R1 rx", rx_data, 0);
    chk(sclk == cpol, "R1 sclk", sclk, cpol);
  endtask

  task automatic t_idle;
    rx_en = 1; #1;
    chk(sdo_oe == 0, "R2 oe follows", sdo_oe, 0);
    rx_en = 0; #1;
    chk(sdo_oe == 1, "R2 oe follows", sdo_oe, 1);
    cpol = 1; #1;
    chk(sclk == 1, "R2 idle sclk", sclk, 1);
    cpol = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick(0);
    chk(busy == 0 && sclk == 0, "R5 idle ticks", {busy, sclk}, 0);
  endtask

  task automatic t_tx(input logic pol, input logic pha, input logic [7:0] d);
    logic [7:0] got;
    logic prev;
    got = '0;
    cpol = pol; cpha = pha; rx_en = 0;
    @(negedge clk);
    chk(sclk == pol, "R2 idle level", sclk, pol);
    write(d);
    chk(busy == 1, "R3 busy", busy, 1);
    chk(sdo_oe == 1, "R3 dir", sdo_oe, 1);
    for (int e = 0; e < 16; e++) begin
      if (!pha && e % 2 == 0) got[7 - e / 2] = sdo;
      prev = sclk;
      if (e == 4) rx_en = 1;
      if (e == 12) rx_en = 0;
      tick(0);
      chk(sclk != prev, "R5 toggle", sclk, !prev);
      if (pha && e % 2 == 0) got[7 - e / 2] = sdo;
      if (e >= 4 && e < 12) chk(sdo_oe == 1, "R4 mid-byte dir", sdo_oe, 1);
    end
    chk(got == d, "R6 msb first", got, d);
    chk(busy == 0, "R11 idle after byte", busy, 0);
    chk(rx_valid == 0, "R8 no pulse in tx", rx_valid, 0);
  endtask

  task automatic t_rx(input logic pha, input logic [7:0] pat);
    cpol = 1; cpha = pha; rx_en = 1;
    @(negedge clk);
    chk(sdo_oe == 0, "R2 input dir", sdo_oe, 0);
    write(8'hFF);
    chk(sdo_oe == 0 && sdo == 0, "R12 quiet pin", {sdo_oe, sdo}, 0);
    for (int e = 0; e < 16; e++) begin
      if (e == 15) begin
        chk(rx_valid == 0, "R8 no early pulse", rx_valid, 0);
        bit_tick = 1; sdi = pat[7 - e / 2];
        @(negedge clk);
        bit_tick = 0;
      end else begin
        tick(pat[7 - e / 2]);
      end
    end
    chk(rx_valid == 1, "R8 pulse", rx_valid, 1);
    chk(rx_data == pat, "R7 sampled byte", rx_data, pat);
    @(negedge clk);
    chk(rx_valid == 0, "R8 single pulse", rx_valid, 0);
    rx_en = 0;
  endtask

  task automatic t_b2b;
    cpol = 0; cpha = 0; rx_en = 0;
    @(negedge clk);
    write(8'hC3);
    tick(0); tick(0);
    write(8'h3C);
    chk(hold_full == 1, "R9 hold", hold_full, 1);
    write(8'hFF);
    chk(hold_full == 1, "R10 ignored", hold_full, 1);
    for (int e = 2; e < 16; e++) begin
      if (e == 10) rx_en = 1;
      if (e == 15) begin
        bit_tick = 1;
        @(negedge clk);
        bit_tick = 0;
      end else begin
        tick(0);
      end
      if (e == 14) chk(sdo_oe == 1, "R4 held till end", sdo_oe, 1);
    end
    chk(busy == 1, "R9 gapless", busy, 1);
    chk(hold_full == 0, "R9 hold cleared", hold_full, 0);
    chk(sdo_oe == 0, "R4 turned at boundary", sdo_oe, 0);
    chk(rx_valid == 0, "R8 tx byte no pulse", rx_valid, 0);
    @(negedge clk);
    for (int e = 0; e < 16; e++) tick(8'hA6 >> (7 - e / 2));
    chk(rx_data == 8'hA6, "R8 second byte rx", rx_data, 8'hA6);
    chk(busy == 0, "R10 third byte dropped", busy, 0);
    rx_en = 0;
    write(8'h81);
    chk(busy == 1, "R11 immediate restart", busy, 1);
    for (int e = 0; e < 16; e++) tick(0);
    chk(busy == 0, "R11 done", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_tx(0, 0, 8'hB5);
    t_tx(0, 1, 8'h6E);
    t_tx(1, 0, 8'h93);
    t_tx(1, 1, 8'h2D);
    t_rx(0, 8'hC9);
    t_rx(1, 8'h5B);
    t_b2b();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule